// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog peripheral that sits on a small byte-wide register bus. It counts ticks from one of two tick-enable inputs. The ticks pass through a fixed power-of-two divider and then a 3-bit selectable prescaler. The prescaler output steps an 8-bit down counter. Software keeps the system alive by servicing the watchdog with two keyed writes in a row. The first write puts 0xA5 into the first key register. The second write puts 0x5A into the second key register. A correct service reloads the counter from the reload register and restarts the divider chain.

Control settings are two-stage. A write to the control register lands in a pending copy. That copy becomes active only when a correct service follows it. The block raises a one-cycle reset request, and sets a sticky timeout flag, in any of these cases:
- the counter runs out;
- the key pair is malformed or interrupted;
- a control write is not followed by a service.

The analog clock sources are represented by the two tick-enable inputs `tick_osc` and `tick_pclk`.

Top module: `wdog_feedguard`

## Requirements
- R1: Register addresses are 0 control, 1 reload, 2 first key, 3 second key. The control byte is bit0 run, bit1 timeout flag, bits 4:2 prescale code, bit5 source select, and bits 7:6 read as 0. The key registers read as 0. After reset the control register reads 0x1C (stopped, code 7, source 0, flag clear), the reload register reads 0xFF, and `wd_rst_req` is low.
- R2: A valid service is a write of 0xA5 to address 2 whose next bus access is a write of 0x5A to address 3. It raises no reset request, and it reloads the counter and restarts the divider.
- R3: Each of these raises `wd_rst_req` in the cycle after the offending write: a value other than 0xA5 written to address 2; any write to address 3 not directly preceded by the first key; a value other than 0x5A written to address 3 after the first key.
- R4: Any other read or write that falls between the first key and the second key raises `wd_rst_req` in the cycle after that access.
- R5: Run, prescale and source values written to the control register take effect only at the next valid service. Until then the previously active values govern counting and read back. If the next access after a control write is not the first key of a service, a reset request follows.
- R6: With run active, the counter steps once every 2^(DIV_LOG2+code+1) selected ticks. The reset request appears (reload+1)·2^(DIV_LOG2+code+1) selected ticks after the service.
- R7: With run inactive, no counting occurs and no reset request comes from the counter.
- R8: Source select 0 counts `tick_osc` and source select 1 counts `tick_pclk`. Ticks on the unselected input have no effect.
- R9: The timeout flag sets with every reset request. Writing 0 to control bit1 clears it at once. Writing 1 to that bit leaves it unchanged.
- R10: `wd_rst_req` is high for exactly one cycle. Bus accesses in that cycle are ignored. A request also clears the key sequence and discards any pending control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| tick_osc | input | 1 | Tick enable from the dedicated slow source |
| tick_pclk | input | 1 | Tick enable from the peripheral clock source |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with DIV_LOG2 = 2 and the default 8-bit counter. With that setting a full timeout with prescale codes 0 to 2 and reload values 0 to 7 ends within a few hundred cycles. This keeps exact timeout-cycle comparisons practical across many random settings and both tick sources. The shorter divider also leaves room for directed cases to show that a pending control value stays inactive through a whole timeout.

// File: rtl/wdog_fg_pkg.sv
package wdog_fg_pkg;

   localparam int PRE_W = 3;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_KEY1   = 2'd2,
      REG_KEY2   = 2'd3
   } reg_sel_e;

   localparam logic [7:0] KEY1_VAL = 8'hA5;
   localparam logic [7:0] KEY2_VAL = 8'h5A;

   typedef struct packed {
      logic             src;
      logic [PRE_W-1:0] pre;
      logic             run;
   } wd_cfg_t;

   localparam wd_cfg_t CFG_RST = '{src: 1'b0, pre: 3'd7, run: 1'b0};

endpackage

// File: rtl/wdog_fg_tick.sv
module wdog_fg_tick
   import wdog_fg_pkg::*;
#(
   parameter int DIV_LOG2 = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_a,
   input  logic             tick_b,
   input  logic             src,
   input  logic [PRE_W-1:0] pre,
   input  logic             run,
   input  logic             clear,
   input  logic             hold,
   output logic             pulse
);
   localparam int PSC_W = 1 << PRE_W;

   logic             tick_sel;
   logic             adv;
   logic             stage;
   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;

   assign tick_sel = src ? tick_b : tick_a;
   assign adv      = run & tick_sel & ~hold;

   generate
      if (DIV_LOG2 > 0) begin : g_fixed_div
         logic [DIV_LOG2-1:0] fix_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       fix_q <= '0;
            else if (clear)   fix_q <= '0;
            else if (adv)     fix_q <= fix_q + 1'b1;
         end
         assign stage = adv & (&fix_q);
      end else begin : g_no_div
         assign stage = adv;
      end
   endgenerate

   assign mask = (PSC_W'(1) << ({1'b0, pre} + 4'd1)) - PSC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       psc_q <= '0;
      else if (clear)   psc_q <= '0;
      else if (stage)   psc_q <= psc_q + 1'b1;
   end

   assign pulse = stage & ((psc_q & mask) == mask);

   // R7: a stopped watchdog produces no counter steps
   a_r7_no_step_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !pulse);
   // R10: nothing advances while a request is out
   a_r10_frozen_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !pulse);

endmodule

// File: rtl/wdog_fg_count.sv
module wdog_fg_count #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             underflow
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '1;
      else if (load)   cnt_q <= load_val;
      else if (dec)    cnt_q <= cnt_q - 1'b1;
   end

   assign underflow = dec & (cnt_q == '0);

   // R6: each step lowers the count by one
   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
   // R2: reload lands the programmed value
   a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/wdog_fg_seq.sv
module wdog_fg_seq
   import wdog_fg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_wr,
   input  logic       acc_rd,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   input  logic       abort,
   output logic       feed_ok,
   output logic       seq_bad
);
   logic     armed_q, armed_d;
   logic     due_q, due_d;
   logic     acc;
   reg_sel_e sel;

   assign acc = acc_wr | acc_rd;
   assign sel = reg_sel_e'(addr);

   always_comb begin
      feed_ok = 1'b0;
      seq_bad = 1'b0;
      armed_d = armed_q;
      due_d   = due_q;
      if (acc) begin
         if (armed_q) begin
            if (acc_wr && sel == REG_KEY2 && wdata == KEY2_VAL) feed_ok = 1'b1;
            else                                               seq_bad = 1'b1;
         end else if (acc_wr && sel == REG_KEY1) begin
            if (wdata == KEY1_VAL) armed_d = 1'b1;
            else                   seq_bad = 1'b1;
         end else if (due_q) begin
            seq_bad = 1'b1;
         end else if (acc_wr && sel == REG_KEY2) begin
            seq_bad = 1'b1;
         end else if (acc_wr && sel == REG_CTRL) begin
            due_d = 1'b1;
         end
      end
      if (feed_ok || seq_bad || abort) begin
         armed_d = 1'b0;
         due_d   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         due_q   <= 1'b0;
      end else begin
         armed_q <= armed_d;
         due_q   <= due_d;
      end
   end

   // R3, R4: a key access is either a service or a fault, never both
   a_r3_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(feed_ok && seq_bad));
   // R2: a service completes only on a write
   a_r2_feed_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      feed_ok |-> acc_wr);

endmodule

// File: rtl/wdog_feedguard.sv
module wdog_feedguard
   import wdog_fg_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int DIV_LOG2   = 5,
   parameter int RELOAD_RST = 255
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       tick_osc,
   input  logic       tick_pclk,
   output logic       wd_rst_req
);
   generate
      if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt_w
         $error("wdog_feedguard: CNT_W must lie in 2..8");
      end
      if (DIV_LOG2 < 0 || DIV_LOG2 > 16) begin : g_bad_div
         $error("wdog_feedguard: DIV_LOG2 must lie in 0..16");
      end
      if (RELOAD_RST < 0 || RELOAD_RST >= (1 << CNT_W)) begin : g_bad_rld
         $error("wdog_feedguard: RELOAD_RST does not fit CNT_W");
      end
   endgenerate

   reg_sel_e         sel;
   wd_cfg_t          cfg_q, cfg_sh;
   logic [CNT_W-1:0] reload_q;
   logic             flag_q;
   logic             acc_wr, acc_rd, ctrl_wr;
   logic             feed_ok, seq_bad, wdclk, uf, rst_evt;

   assign sel     = reg_sel_e'(bus_addr);
   assign acc_wr  = bus_wr & ~wd_rst_req;
   assign acc_rd  = bus_rd & ~wd_rst_req;
   assign ctrl_wr = acc_wr && sel == REG_CTRL;
   assign rst_evt = seq_bad | (uf & ~feed_ok);

   wdog_fg_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_wr  (acc_wr),
      .acc_rd  (acc_rd),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .abort   (uf),
      .feed_ok (feed_ok),
      .seq_bad (seq_bad)
   );

   wdog_fg_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_a (tick_osc),
      .tick_b (tick_pclk),
      .src    (cfg_q.src),
      .pre    (cfg_q.pre),
      .run    (cfg_q.run),
      .clear  (feed_ok | rst_evt),
      .hold   (wd_rst_req),
      .pulse  (wdclk)
   );

   wdog_fg_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (feed_ok | rst_evt),
      .load_val  (reload_q),
      .dec       (wdclk),
      .underflow (uf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= CFG_RST;
         cfg_sh     <= CFG_RST;
         reload_q   <= CNT_W'(RELOAD_RST);
         flag_q     <= 1'b0;
         wd_rst_req <= 1'b0;
      end else begin
         wd_rst_req <= rst_evt;
         if (acc_wr && sel == REG_RELOAD) reload_q <= bus_wdata[CNT_W-1:0];
         if (rst_evt) begin
            flag_q <= 1'b1;
            cfg_sh <= cfg_q;
         end else begin
            if (ctrl_wr) begin
               cfg_sh <= '{src: bus_wdata[5], pre: bus_wdata[4:2], run: bus_wdata[0]};
               if (!bus_wdata[1]) flag_q <= 1'b0;
            end
            if (feed_ok) cfg_q <= cfg_sh;
         end
      end
   end

   always_comb begin
      case (sel)
         REG_CTRL:   bus_rdata = {2'b00, cfg_q.src, cfg_q.pre, flag_q, cfg_q.run};
         REG_RELOAD: bus_rdata = 8'(reload_q);
         default:    bus_rdata = 8'h00;
      endcase
   end

   // R10: the request never lasts two cycles
   a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |=> !wd_rst_req);
   // R9: every request leaves the flag set
   a_r9_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |-> flag_q);
   // R5: active settings move only on a service
   a_r5_cfg_on_feed_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(feed_ok) |-> $stable(cfg_q));

endmodule

// File: tb/wdog_feedguard_bench.sv
module wdog_feedguard_bench;
   localparam int DIVL = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       tick_osc = 1'b0, tick_pclk = 1'b0;
   logic       wd_rst_req;

   int  n_chk = 0, n_bad = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   wdog_feedguard #(.DIV_LOG2(DIVL)) u_wdog_feedguard (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_osc(tick_osc), .tick_pclk(tick_pclk), .wd_rst_req(wd_rst_req)
   );

   function automatic int exp_period(int rl, int code);
      return (rl + 1) << (DIVL + code + 1);
   endfunction

   function automatic logic [7:0] ctrl_byte(bit src, int code, bit flag, bit run);
      return {2'b00, src, 3'(code), flag, run};
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // callers sit at a negedge; returns at the next negedge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic feed();
      wr(2'd2, 8'hA5);
      wr(2'd3, 8'h5A);
   endtask

   task automatic wait_req(input int start, input int limit, output int n);
      n = start;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (wd_rst_req) return;
      end
      n = -1;
   endtask

   task automatic stop_and_clear();
      wr(2'd0, ctrl_byte(1'b0, 0, 1'b0, 1'b0));
      feed();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int n, rl, code;
      bit src;
      void'($urandom(32'd4177));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 req low", int'(wd_rst_req), 0);
      rd(2'd0, d); chk("R1 ctrl reset", d, 8'h1C);
      rd(2'd1, d); chk("R1 reload reset", d, 8'hFF);
      rd(2'd2, d); chk("R1 key reads zero", d, 0);

      // R7 stopped: ticks present, service allowed, no request
      tick_osc = 1'b1; tick_pclk = 1'b1;
      wr(2'd1, 8'd0);
      feed();
      chk("R2 valid feed no req", int'(wd_rst_req), 0);
      wait_req(0, 300, n);
      chk("R7 stopped no req", n, -1);

      // R6 R8 R2 random timeouts
      for (int it = 0; it < 10; it++) begin
         rl = $urandom_range(7, 0); code = $urandom_range(2, 0); src = 1'($urandom_range(1, 0));
         tick_osc = ~src; tick_pclk = src;
         wr(2'd1, 8'(rl));
         wr(2'd0, ctrl_byte(src, code, 1'b0, 1'b1));
         feed();
         wait_req(0, 2000, n);
         chk("R6 timeout cycles", n, exp_period(rl, code));
         @(negedge clk);
         chk("R10 pulse ends", int'(wd_rst_req), 0);
         rd(2'd0, d);
         chk("R9 flag set", int'(d[1]), 1);
         stop_and_clear();
         rd(2'd0, d);
         chk("R5 R9 stop and clear", d, ctrl_byte(1'b0, 0, 1'b0, 1'b0));
      end

      // R8 unselected source ignored
      tick_osc = 1'b0; tick_pclk = 1'b1;
      wr(2'd0, ctrl_byte(1'b0, 0, 1'b0, 1'b1));
      feed();
      wait_req(0, 100, n);
      chk("R8 unselected ticks", n, -1);
      stop_and_clear();

      // R5 pending stop does not take effect before a service
      tick_osc = 1'b1; tick_pclk = 1'b0;
      wr(2'd1, 8'd3);
      wr(2'd0, ctrl_byte(1'b0, 0, 1'b0, 1'b1));
      feed();
      wr(2'd0, ctrl_byte(1'b0, 0, 1'b0, 1'b0));
      wait_req(1, 200, n);
      chk("R5 pending ignored", n, exp_period(3, 0));
      @(negedge clk);
      rd(2'd0, d);
      chk("R5 R10 pending dropped", d, ctrl_byte(1'b0, 0, 1'b1, 1'b1));
      // R9 writing 1 to the flag keeps it
      wr(2'd0, ctrl_byte(1'b0, 0, 1'b1, 1'b0));
      feed();
      rd(2'd0, d);
      chk("R9 write one keeps flag", d, ctrl_byte(1'b0, 0, 1'b1, 1'b0));
      stop_and_clear();

      // R5 control write followed by a non-key access
      wr(2'd0, ctrl_byte(1'b0, 1, 1'b0, 1'b0));
      rd(2'd1, d);
      chk("R5 unfed ctrl", int'(wd_rst_req), 1);
      // R10 access during the pulse ignored
      wr(2'd3, 8'h00);
      chk("R10 access ignored", int'(wd_rst_req), 0);
      rd(2'd0, d);
      chk("R10 pending discarded", d, ctrl_byte(1'b0, 0, 1'b1, 1'b0));

      // R3 malformed keys, R4 interrupted pairs, mixed randomly
      for (int it = 0; it < 12; it++) begin
         case ($urandom_range(4, 0))
            0: wr(2'd2, 8'(8'hA5 ^ 8'($urandom_range(255, 1))));
            1: wr(2'd3, 8'h5A);
            2: begin wr(2'd2, 8'hA5); wr(2'd3, 8'(8'h5A ^ 8'($urandom_range(255, 1)))); end
            3: begin wr(2'd2, 8'hA5); rd(2'($urandom_range(1, 0)), d); end
            default: begin wr(2'd2, 8'hA5); wr(2'd1, 8'd5); end
         endcase
         chk("R3 R4 bad sequence req", int'(wd_rst_req), 1);
         @(negedge clk);
         feed();
         chk("R2 feed after fault", int'(wd_rst_req), 0);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule